// File: doc/BRIEF.md
# Absmean Ternary Weight Quantizer

This block turns a block of signed fixed-point weights into ternary codes plus the data needed to rebuild one scale for the whole block. The scale is the mean absolute value of the weights in the block. Weights are taken in on a valid/last stream and written into an internal buffer. While they arrive, the block adds up their magnitudes and counts them. Once the final weight is in, the block replays the buffer in arrival order and emits one 2-bit code for each weight. A weight maps to zero when its magnitude is below half the scale. Any other weight maps to its sign. After the last code, a one-cycle done strobe presents three values: the magnitude sum, the weight count and the number of zero codes.

The block never divides. The mean-based test |w| ≥ (Σ|w| / n) / 2 is rewritten as 2·n·|w| ≥ Σ|w|, and that comparison runs in a single cycle per weight. Downstream logic keeps the sum and count as the block's scale (sum / count). It applies that scale once, after its adder-only dot product.

Top module: `absmean_ternarizer`

## Requirements
- R1: With `done_o`, `mag_sum_o` equals the sum of |w| over the block and `blk_count_o` equals the number of weights accepted. `done_o` is a one-cycle pulse in the cycle right after the final code.
- R2: Each accepted weight yields exactly one code, in arrival order. The encodings are 2'b00 for zero, 2'b01 for +1 and 2'b11 for −1. 2'b10 never appears on a valid code.
- R3: A weight with 2·n·|w| > Σ|w| gets the code of its sign: 2'b01 if positive, 2'b11 if negative.
- R4: A nonzero weight with 2·n·|w| < Σ|w| gets code 2'b00.
- R5: A weight whose magnitude is exactly half the scale (2·n·|w| = Σ|w|) gets the code of its sign (rounding half away from zero).
- R6: The most negative input code (−128 at the default width) counts as magnitude 128 in the sum and maps to 2'b11. It does not wrap.
- R7: If every weight in the block is zero, every code is 2'b00, the reported sum is 0 and the zero count equals n.
- R8: With `done_o`, `zero_count_o` equals the number of 2'b00 codes emitted for the block.
- R9: `in_ready_o` is low from the cycle after the final weight is accepted until `done_o`. Input offered in that window is ignored and changes neither the codes nor the count.
- R10: When DEPTH weights have been accepted without `in_last_i`, the block ends as if the last one had been marked last, and reports `blk_count_o` = DEPTH.
- R11: After reset, `in_ready_o` is 1 and both `code_valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Weight on `in_data_i` is offered |
| in_data_i | input | W_W | Signed two's-complement weight |
| in_last_i | input | 1 | Offered weight is the last of the block |
| in_ready_o | output | 1 | Block accepts weights (collecting phase) |
| code_valid_o | output | 1 | `code_o` holds a ternary code |
| code_o | output | 2 | Ternary code: 00 zero, 01 +1, 11 −1 |
| done_o | output | 1 | One-cycle strobe: block finished, totals valid |
| mag_sum_o | output | SUM_W | Sum of weight magnitudes |
| blk_count_o | output | CNT_W | Number of weights in the block |
| zero_count_o | output | CNT_W | Number of zero codes in the block |

## Verification
Some properties are checked by assertions on every cycle:
- No valid code ever carries the unused encoding.
- The input side stays closed while codes are being emitted.
- The done strobe always follows a code in the cycle before it.
- The reported zero count never exceeds the weight count.
- The weight count never exceeds the buffer depth.

Other behaviour can only be shown by the bench's directed blocks, because they depend on the actual numbers:
- Whether a given weight rounds to zero or to its sign, including the exact half-scale tie and the most negative input.
- The values of the sum and the zero count.
- That input offered while the block is busy leaves no trace in the results.

// File: rtl/ternq_pkg.sv
package ternq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_EMIT   = 2'd2,
    ST_REPORT = 2'd3
  } tq_state_e;

  localparam logic [1:0] TQ_ZERO = 2'b00;
  localparam logic [1:0] TQ_POS  = 2'b01;
  localparam logic [1:0] TQ_NEG  = 2'b11;
endpackage

// File: rtl/ternq_mag.sv
module ternq_mag #(
  parameter int W_W = 8,
  localparam int MAG_W = W_W + 1
) (
  input  logic [W_W-1:0]   w_i,
  output logic [MAG_W-1:0] mag_o
);
  logic [MAG_W-1:0] wide;

  always_comb begin
    wide = {w_i[W_W-1], w_i};
    if (w_i[W_W-1]) mag_o = '0 - wide;
    else            mag_o = wide;
  end
endmodule

// File: rtl/ternq_buf.sv
module ternq_buf #(
  parameter int W_W   = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W_W-1:0]   wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W_W-1:0]   rd_data_o
);
  logic [W_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/ternq_accum.sv
module ternq_accum #(
  parameter int W_W   = 8,
  parameter int DEPTH = 16,
  localparam int MAG_W = W_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = MAG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en_i,
  input  logic             first_i,
  input  logic [W_W-1:0]   w_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [MAG_W-1:0] mag;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  ternq_mag #(.W_W(W_W)) u_mag (.w_i(w_i), .mag_o(mag));

  always_comb begin
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (acc_en_i) begin
      if (first_i) begin
        sum_d = SUM_W'(mag);
        cnt_d = CNT_W'(1);
      end else begin
        sum_d = sum_q + SUM_W'(mag);
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (acc_en_i) begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ternq_decide.sv
module ternq_decide #(
  parameter int W_W   = 8,
  parameter int DEPTH = 16,
  localparam int MAG_W  = W_W + 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUM_W  = MAG_W + CNT_W,
  localparam int PROD_W = SUM_W + 1
) (
  input  logic [W_W-1:0]   w_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [1:0]       code_o,
  output logic             zero_o
);
  import ternq_pkg::*;

  logic [MAG_W-1:0]  mag;
  logic [PROD_W-1:0] lhs;
  logic              keep;

  ternq_mag #(.W_W(W_W)) u_mag (.w_i(w_i), .mag_o(mag));

  always_comb begin
    lhs  = (PROD_W'(mag) << 1) * PROD_W'(n_i);
    keep = (mag != '0) && (lhs >= PROD_W'(sum_i));
    if (!keep)              code_o = TQ_ZERO;
    else if (w_i[W_W-1])    code_o = TQ_NEG;
    else                    code_o = TQ_POS;
    zero_o = !keep;
  end
endmodule

// File: rtl/absmean_ternarizer.sv
module absmean_ternarizer #(
  parameter int W_W   = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MAG_W = W_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = MAG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [W_W-1:0]   in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             code_valid_o,
  output logic [1:0]       code_o,
  output logic             done_o,
  output logic [SUM_W-1:0] mag_sum_o,
  output logic [CNT_W-1:0] blk_count_o,
  output logic [CNT_W-1:0] zero_count_o
);
  import ternq_pkg::*;

  tq_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] zeros_q, zeros_d;
  logic [1:0]       code_q, code_d;
  logic             cv_q, cv_d;
  logic             done_q, done_d;

  logic             accept, first, end_blk, last_idx;
  logic [CNT_W-1:0] wr_pos, cnt;
  logic [SUM_W-1:0] sum;
  logic [W_W-1:0]   rd_w;
  logic [1:0]       dec_code;
  logic             dec_zero;

  assign in_ready_o = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign accept     = in_valid_i && in_ready_o;
  assign first      = (state_q == ST_IDLE);
  assign wr_pos     = first ? '0 : cnt;
  assign end_blk    = accept && (in_last_i || (wr_pos == CNT_W'(DEPTH - 1)));
  assign last_idx   = (CNT_W'(idx_q) == cnt - CNT_W'(1));

  ternq_buf #(.W_W(W_W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .wr_en_i   (accept),
    .wr_idx_i  (wr_pos[IDX_W-1:0]),
    .wr_data_i (in_data_i),
    .rd_idx_i  (idx_q),
    .rd_data_o (rd_w)
  );

  ternq_accum #(.W_W(W_W), .DEPTH(DEPTH)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en_i (accept),
    .first_i  (first),
    .w_i      (in_data_i),
    .sum_o    (sum),
    .cnt_o    (cnt)
  );

  ternq_decide #(.W_W(W_W), .DEPTH(DEPTH)) u_dec (
    .w_i    (rd_w),
    .n_i    (cnt),
    .sum_i  (sum),
    .code_o (dec_code),
    .zero_o (dec_zero)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    zeros_d = zeros_q;
    code_d  = code_q;
    cv_d    = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE, ST_LOAD: begin
        if (end_blk) begin
          state_d = ST_EMIT;
          idx_d   = '0;
          zeros_d = '0;
        end else if (accept) begin
          state_d = ST_LOAD;
        end
      end
      ST_EMIT: begin
        cv_d   = 1'b1;
        code_d = dec_code;
        if (dec_zero) zeros_d = zeros_q + CNT_W'(1);
        idx_d  = idx_q + IDX_W'(1);
        if (last_idx) state_d = ST_REPORT;
      end
      ST_REPORT: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      zeros_q <= '0;
      code_q  <= TQ_ZERO;
      cv_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      zeros_q <= zeros_d;
      code_q  <= code_d;
      cv_q    <= cv_d;
      done_q  <= done_d;
    end
  end

  assign code_valid_o = cv_q;
  assign code_o       = code_q;
  assign done_o       = done_q;
  assign mag_sum_o    = sum;
  assign blk_count_o  = cnt;
  assign zero_count_o = zeros_q;

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> (code_o != 2'b10));

  // R9
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> !in_ready_o);

  // R1
  done_after_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(code_valid_o));

  // R8
  zero_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zero_count_o <= blk_count_o));
endmodule

// File: tb/absmean_ternarizer_test.sv
module absmean_ternarizer_test;
  localparam int W_W   = 8;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = W_W + 1 + CNT_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_last;
  logic [W_W-1:0]   in_data;
  logic             in_ready, code_valid, done;
  logic [1:0]       code;
  logic [SUM_W-1:0] mag_sum;
  logic [CNT_W-1:0] blk_count, zero_count;

  int checks = 0;
  int failures = 0;
  int blk [0:31];
  int got [0:63];
  int ncode;
  bit collecting = 1'b0;
  bit busy_leak;

  always #2 clk = ~clk;

  absmean_ternarizer #(.W_W(W_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .code_valid_o(code_valid), .code_o(code),
    .done_o(done), .mag_sum_o(mag_sum), .blk_count_o(blk_count),
    .zero_count_o(zero_count)
  );

  always @(negedge clk) begin
    if (collecting && code_valid) begin
      if (ncode < 64) got[ncode] = int'(code);
      ncode++;
      if (in_ready) busy_leak = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc(input int v);
    return (v == 0) ? 0 : ((v > 0) ? 1 : 3);
  endfunction

  // Feeds blk[0..n-1]; marks last unless no_last; junk keeps input offered while busy.
  task automatic run_block(input int n, input bit no_last, input bit junk, input string req);
    int sum = 0;
    int zeros = 0;
    int exp_code [0:31];
    int wait_cyc = 0;
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) sum += (blk[i] < 0) ? -blk[i] : blk[i];
    for (int i = 0; i < n; i++) begin
      int m = (blk[i] < 0) ? -blk[i] : blk[i];
      if (m != 0 && 2 * n * m >= sum) exp_code[i] = enc(blk[i]);
      else begin exp_code[i] = 0; zeros++; end
    end
    ncode = 0;
    busy_leak = 1'b0;
    collecting = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W_W'(blk[i]);
      in_last  = (!no_last) && (i == n - 1);
    end
    @(negedge clk);
    if (junk) begin
      in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
    end else begin
      in_valid = 1'b0; in_last = 1'b0;
    end
    while (!seen && wait_cyc < 200) begin
      if (done) begin
        seen = 1'b1;
        in_valid = 1'b0; in_last = 1'b0;
      end else begin
        @(negedge clk);
        wait_cyc++;
      end
    end
    collecting = 1'b0;
    chk(seen, {req, " done seen"}, int'(seen), 1);
    if (seen) begin
      chk(ncode == n, {req, " R2 code count"}, ncode, n);
      for (int i = 0; i < n && i < ncode; i++)
        chk(got[i] == exp_code[i], {req, " R2 code value"}, got[i], exp_code[i]);
      chk(int'(mag_sum) == sum, {req, " R1 sum"}, int'(mag_sum), sum);
      chk(int'(blk_count) == n, {req, " R1 count"}, int'(blk_count), n);
      chk(int'(zero_count) == zeros, {req, " R8 zero count"}, int'(zero_count), zeros);
      chk(!busy_leak, {req, " R9 ready low while emitting"}, int'(busy_leak), 0);
      @(negedge clk);
      chk(done == 1'b0, {req, " R1 done is one pulse"}, int'(done), 0);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
    chk(code_valid == 1'b0, "R11 code_valid after reset", int'(code_valid), 0);
    chk(done == 1'b0, "R11 done after reset", int'(done), 0);
  endtask

  task automatic t_mixed();
    // sum 40, n 8: nonzero when 16*|w| >= 40, i.e. |w| >= 3 (R3, R4)
    blk[0] = 10; blk[1] = -9; blk[2] = 2; blk[3] = -2;
    blk[4] = 5;  blk[5] = -4; blk[6] = 1; blk[7] = 7;
    run_block(8, 1'b0, 1'b0, "R3/R4 mixed");
  endtask

  task automatic t_tie();
    // sum 8, n 4: |w|=1 gives 8*1 == 8, rounds away from zero (R5)
    blk[0] = 6; blk[1] = -1; blk[2] = 1; blk[3] = 0;
    run_block(4, 1'b0, 1'b0, "R5 tie");
  endtask

  task automatic t_all_zero();
    for (int i = 0; i < 5; i++) blk[i] = 0;
    run_block(5, 1'b0, 1'b0, "R7 all zero");
  endtask

  task automatic t_most_negative();
    blk[0] = -128; blk[1] = 0; blk[2] = 0; blk[3] = 1;
    run_block(4, 1'b0, 1'b0, "R6 most negative");
  endtask

  task automatic t_single();
    blk[0] = -3;
    run_block(1, 1'b0, 1'b0, "R3 single weight");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) blk[i] = (i % 3 == 0) ? -(i + 1) : i;
    run_block(DEPTH, 1'b1, 1'b0, "R10 full buffer");
  endtask

  task automatic t_busy_junk();
    blk[0] = 20; blk[1] = -1; blk[2] = -30;
    run_block(3, 1'b0, 1'b1, "R9 input while busy");
    // follow-up block proves junk did not start a block or alter totals
    blk[0] = 2; blk[1] = -2;
    run_block(2, 1'b0, 1'b0, "R9 block after busy");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_tie();
    t_all_zero();
    t_most_negative();
    t_single();
    t_full();
    t_busy_junk();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule